// File: doc/BRIEF.md
# T1 Robbed-Bit Signaling Extractor

This block pulls robbed-bit signaling out of an already framed T1 receive stream carrying 24 channels. Each cycle with `in_valid` high delivers one payload bit together with its frame number inside the multiframe, its channel number and its bit position in the channel slot. The framing bit is not presented. The least significant payload bit of each channel in every sixth frame is collected into a per-channel codeword. It is read according to the selected superframe format (12 frames) or extended superframe format (24 frames), and in extended superframe format according to the 4-state or 16-state choice.

Codewords can be debounced across two multiframes. They are discarded whenever loss of frame, an elastic-store slip or the freeze control shows up during the multiframe that produced them, and they are gated by a per-channel extract enable. The stored nibble of each channel is replayed on a serial signaling output that runs beside a one-cycle delayed copy of the data. Sticky per-channel change flags feed a maskable level interrupt.

Top module: `rbs_extract`

## Requirements
- R1: In superframe format (`esf_mode`=0, frames 1..12), bit 8 (`bit_num`=7) of frames 6 and 12 gives A and B; the stored nibble is {A,B,A,B} with A in nibble bit 3.
- R2: In extended superframe format with `sixteen_state`=1 (frames 1..24), bit 8 of frames 6, 12, 18 and 24 gives A, B, C and D, stored as {A,B,C,D} with A in bit 3.
- R3: In extended superframe format with `sixteen_state`=0, A is taken from frame 18 and B from frame 24, and the stored nibble is {A,B,A,B}.
- R4: A channel's codeword is committed at that channel's bit 8 of the last frame of the multiframe; the serial output of that same bit still shows the old nibble.
- R5: A codeword is stored only for channels whose `extract_en` bit is 1; other channels keep their nibble and raise no change flag.
- R6: With `deb_en`=1, a channel's nibble updates only when its codeword equals the codeword received in the previous accepted multiframe.
- R7: If `lof`, `slip` or `freeze_en` is high in any cycle of a multiframe (from frame 1, channel 0, bit 0 up to the commit), that multiframe's codewords are discarded and the stored nibbles hold.
- R8: A commit that changes a channel's stored nibble sets that channel's bit in `cos_flags`.
- R9: A flag stays set until a one-cycle pulse on the matching `cos_clr` bit clears it.
- R10: `irq` is a registered copy of `sig_ie` AND (any `cos_flags` bit), one cycle behind the flags.
- R11: `out_valid` and `data_out` repeat `in_valid` and `rx_bit` one cycle later; `sig_out` carries the channel's stored A,B,C,D in slot bits 5..8 (`bit_num` 4..7) in the same delayed cycle, and 0 in bits 1..4.
- R12: After reset, every stored nibble and every debounce history is 0000, and `cos_flags`, `irq`, `out_valid`, `data_out` and `sig_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload bit present this cycle |
| rx_bit | input | 1 | Received payload bit |
| frame_num | input | 5 | Frame inside the multiframe, 1-based |
| chan_num | input | 5 | Channel, 0..23 |
| bit_num | input | 3 | Bit inside the slot, 0 = bit 1, 7 = bit 8 |
| esf_mode | input | 1 | 1 = 24-frame format, 0 = 12-frame format |
| sixteen_state | input | 1 | 1 = four-bit signaling in 24-frame format |
| deb_en | input | 1 | Two-multiframe debounce enable |
| freeze_en | input | 1 | Manual freeze |
| lof | input | 1 | Loss of frame status |
| slip | input | 1 | Elastic-store slip status |
| extract_en | input | 24 | Per-channel extract enable |
| cos_clr | input | 24 | Per-channel change flag clear strobe |
| sig_ie | input | 1 | Interrupt enable |
| out_valid | output | 1 | Delayed `in_valid` |
| data_out | output | 1 | Delayed `rx_bit` |
| sig_out | output | 1 | Serial signaling aligned with `data_out` |
| cos_flags | output | 24 | Sticky change-of-state flags |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that codewords only enter on `in_valid` cycles, that position markers stay in range (channel below 24, frame within the selected multiframe length), and that a clear strobe is applied while no bit is being delivered. The stimulus follows these rules. It walks complete multiframes in order with the markers always legal. It raises faults only in frame 3 or for a whole multiframe, and it pulses clears in idle cycles, so every flag change traces back to one commit or one strobe.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int SIG_STEP = 6;   // signaling frame spacing
  localparam int SF_LEN   = 12;  // frames per superframe
  localparam int ESF_LEN  = 24;  // frames per extended superframe
  typedef logic [3:0] nib_t;
endpackage

// File: rtl/rbs_capture.sv
module rbs_capture
  import rbs_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CHW = 5,
  parameter int FRW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           rx_bit,
  input  logic [FRW-1:0] frame_num,
  input  logic [CHW-1:0] chan_num,
  input  logic [2:0]     bit_num,
  input  logic           esf_mode,
  input  logic           sixteen_state,
  input  logic           fault,
  output logic           cw_valid,
  output logic [CHW-1:0] cw_chan,
  output nib_t           cw_word,
  output logic           cw_drop
);
  localparam logic [FRW-1:0] STEP_F = FRW'(SIG_STEP);
  localparam logic [FRW-1:0] SF_F   = FRW'(SF_LEN);
  localparam logic [FRW-1:0] ESF_F  = FRW'(ESF_LEN);

  nib_t           acc_q [NCH];
  logic           taint_q;
  logic [FRW-1:0] last_f;
  logic           sig_hit, mf_start;
  logic [1:0]     slot_k;
  nib_t           cur;

  assign last_f   = esf_mode ? ESF_F : SF_F;
  assign sig_hit  = in_valid && (bit_num == 3'd7) && (frame_num != '0) &&
                    ((frame_num % STEP_F) == '0) && (frame_num <= last_f);
  assign slot_k   = 2'(frame_num / STEP_F - 1'b1);
  assign mf_start = in_valid && (frame_num == FRW'(1)) &&
                    (chan_num == '0) && (bit_num == 3'd0);

  always_comb begin
    cur = acc_q[chan_num];
    cur[~slot_k] = rx_bit;
  end

  always_comb begin
    if (!esf_mode)          cw_word = {cur[3], cur[2], cur[3], cur[2]};
    else if (sixteen_state) cw_word = cur;
    else                    cw_word = {cur[1], cur[0], cur[1], cur[0]};
  end

  assign cw_valid = sig_hit && (frame_num == last_f);
  assign cw_chan  = chan_num;
  assign cw_drop  = taint_q | fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) acc_q[i] <= '0;
    end else if (sig_hit) begin
      acc_q[chan_num] <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           taint_q <= 1'b0;
    else if (mf_start) taint_q <= fault;
    else if (fault)    taint_q <= 1'b1;
  end
endmodule

// File: rtl/rbs_store.sv
module rbs_store
  import rbs_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cw_valid,
  input  logic [CHW-1:0] cw_chan,
  input  nib_t           cw_word,
  input  logic           cw_drop,
  input  logic           deb_en,
  input  logic [NCH-1:0] extract_en,
  input  logic [NCH-1:0] cos_clr,
  input  logic [CHW-1:0] rd_chan,
  output nib_t           rd_word,
  output logic [NCH-1:0] cos_flags
);
  nib_t store_q [NCH];
  nib_t prev_q  [NCH];
  logic accept, commit, changed;

  assign accept  = cw_valid && !cw_drop;
  assign commit  = accept && extract_en[cw_chan] &&
                   (!deb_en || (prev_q[cw_chan] == cw_word));
  assign changed = commit && (store_q[cw_chan] != cw_word);
  assign rd_word = store_q[rd_chan];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        store_q[i] <= '0;
        prev_q[i]  <= '0;
      end
    end else begin
      if (accept) prev_q[cw_chan]  <= cw_word;
      if (commit) store_q[cw_chan] <= cw_word;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_cos
    always_ff @(posedge clk) begin
      if (rst)                                   cos_flags[g] <= 1'b0;
      else if (changed && cw_chan == CHW'(g))    cos_flags[g] <= 1'b1;
      else if (cos_clr[g])                       cos_flags[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/rbs_serial.sv
module rbs_serial
  import rbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       rx_bit,
  input  logic [2:0] bit_num,
  input  nib_t       word,
  output logic       out_valid,
  output logic       data_out,
  output logic       sig_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      data_out  <= 1'b0;
      sig_out   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      data_out  <= in_valid & rx_bit;
      sig_out   <= in_valid & bit_num[2] & word[~bit_num[1:0]];
    end
  end
endmodule

// File: rtl/rbs_extract.sv
module rbs_extract
  import rbs_pkg::*;
#(
  parameter int NCH = 24,
  parameter int CHW = 5,
  parameter int FRW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           rx_bit,
  input  logic [FRW-1:0] frame_num,
  input  logic [CHW-1:0] chan_num,
  input  logic [2:0]     bit_num,
  input  logic           esf_mode,
  input  logic           sixteen_state,
  input  logic           deb_en,
  input  logic           freeze_en,
  input  logic           lof,
  input  logic           slip,
  input  logic [NCH-1:0] extract_en,
  input  logic [NCH-1:0] cos_clr,
  input  logic           sig_ie,
  output logic           out_valid,
  output logic           data_out,
  output logic           sig_out,
  output logic [NCH-1:0] cos_flags,
  output logic           irq
);
  logic           fault, cw_valid, cw_drop;
  logic [CHW-1:0] cw_chan;
  nib_t           cw_word, rd_word;

  assign fault = lof | slip | freeze_en;

  rbs_capture #(.NCH(NCH), .CHW(CHW), .FRW(FRW)) u_cap (
    .clk, .rst, .in_valid, .rx_bit, .frame_num, .chan_num, .bit_num,
    .esf_mode, .sixteen_state, .fault,
    .cw_valid, .cw_chan, .cw_word, .cw_drop
  );

  rbs_store #(.NCH(NCH), .CHW(CHW)) u_store (
    .clk, .rst, .cw_valid, .cw_chan, .cw_word, .cw_drop, .deb_en,
    .extract_en, .cos_clr, .rd_chan(chan_num), .rd_word, .cos_flags
  );

  rbs_serial u_ser (
    .clk, .rst, .in_valid, .rx_bit, .bit_num, .word(rd_word),
    .out_valid, .data_out, .sig_out
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= sig_ie & (|cos_flags);
  end
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int NCH = 24
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [2:0]     bit_num,
  input logic           freeze_en,
  input logic           lof,
  input logic           slip,
  input logic [NCH-1:0] extract_en,
  input logic [NCH-1:0] cos_clr,
  input logic           sig_ie,
  input logic           out_valid,
  input logic           sig_out,
  input logic [NCH-1:0] cos_flags,
  input logic           irq
);
  assert_freeze_no_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (lof || slip || freeze_en) |=> ((cos_flags & ~$past(cos_flags)) == '0));

  assert_extract_gate_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((cos_flags & ~$past(cos_flags) & ~$past(extract_en)) == '0));

  assert_flag_needs_bit_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ((cos_flags & ~$past(cos_flags)) == '0));

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && cos_clr != '0) |=> ((cos_flags & $past(cos_clr)) == '0));

  assert_irq_enable_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == ($past(sig_ie) && ($past(cos_flags) != '0))));

  assert_valid_delay_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)));

  assert_sig_slot_R11: assert property (@(posedge clk) disable iff (rst)
    sig_out |-> ($past(in_valid) && $past(bit_num) >= 3'd4));
endmodule

bind rbs_extract rbs_checker #(.NCH(NCH)) u_chk (
  .clk, .rst, .in_valid, .bit_num, .freeze_en, .lof, .slip, .extract_en,
  .cos_clr, .sig_ie, .out_valid, .sig_out, .cos_flags, .irq
);

// File: tb/tb_rbs_extract.sv
`timescale 1ns/1ps
module tb_rbs_extract;
  localparam int NCH = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, in_valid, rx_bit, esf_mode, sixteen_state, deb_en;
  logic freeze_en, lof, slip, sig_ie;
  logic [4:0] frame_num, chan_num;
  logic [2:0] bit_num;
  logic [NCH-1:0] extract_en, cos_clr;
  logic out_valid, data_out, sig_out, irq;
  logic [NCH-1:0] cos_flags;

  rbs_extract dut (.*);

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R11";

  typedef struct packed { logic d; logic s; } exp_t;
  exp_t q[$];

  logic [3:0] words [NCH];
  logic [3:0] m_store [NCH];
  logic [3:0] m_prev [NCH];
  logic [NCH-1:0] m_cos;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per delayed output bit
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) chk({cur_req, " R11 queue empty"}, 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk({cur_req, " R4 R11 data"}, {31'd0, data_out}, {31'd0, e.d});
        chk({cur_req, " R4 R11 sig"},  {31'd0, sig_out},  {31'd0, e.s});
      end
    end
  end

  function automatic void set_words(input int seed);
    for (int c = 0; c < NCH; c++) words[c] = 4'((c * 5 + seed * 3) ^ seed ^ (c >> 2));
  endfunction

  // fk: 0 none, 1 lof in frame 3, 2 slip in frame 3, 3 freeze whole multiframe
  task automatic run_mf(input bit esf, input bit six, input int fk);
    int last;
    bit disc;
    last = esf ? 24 : 12;
    disc = (fk != 0);
    for (int f = 1; f <= last; f++) begin
      for (int c = 0; c < NCH; c++) begin
        for (int b = 0; b < 8; b++) begin
          logic bv, sv;
          exp_t e;
          @(negedge clk);
          in_valid = 1; frame_num = 5'(f); chan_num = 5'(c); bit_num = 3'(b);
          esf_mode = esf; sixteen_state = six;
          lof  = (fk == 1 && f == 3);
          slip = (fk == 2 && f == 3);
          freeze_en = (fk == 3);
          if (b == 7 && f % 6 == 0) bv = words[c][3 - (f / 6 - 1)];
          else bv = ((c + f + b) % 3) == 0;
          rx_bit = bv;
          sv = (b >= 4) ? m_store[c][7 - b] : 1'b0;
          e.d = bv; e.s = sv;
          q.push_back(e);
          if (b == 7 && f == last && !disc) begin
            logic [3:0] w, cw;
            w = words[c];
            if (!esf)     cw = {w[3], w[2], w[3], w[2]};
            else if (six) cw = w;
            else          cw = {w[1], w[0], w[1], w[0]};
            if (extract_en[c] && (!deb_en || m_prev[c] == cw)) begin
              if (m_store[c] != cw) m_cos[c] = 1'b1;
              m_store[c] = cw;
            end
            m_prev[c] = cw;
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 0; lof = 0; slip = 0; freeze_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_flags(input string req);
    chk({req, " R8 flags"}, 32'(cos_flags), 32'(m_cos));
    chk({req, " R10 irq"}, {31'd0, irq}, {31'd0, sig_ie & (|m_cos)});
  endtask

  task automatic clear_flags(input logic [NCH-1:0] mask);
    @(negedge clk); cos_clr = mask;
    @(negedge clk); cos_clr = '0;
    m_cos &= ~mask;
    @(negedge clk);
    check_flags("R9");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; rx_bit = 0; frame_num = 0; chan_num = 0; bit_num = 0;
    esf_mode = 0; sixteen_state = 0; deb_en = 0; freeze_en = 0; lof = 0; slip = 0;
    extract_en = '1; cos_clr = '0; sig_ie = 1; m_cos = '0;
    for (int c = 0; c < NCH; c++) begin m_store[c] = '0; m_prev[c] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 flags", 32'(cos_flags), 0);
    chk("R12 irq", {31'd0, irq}, 0);
    chk("R12 out_valid", {31'd0, out_valid}, 0);
    chk("R12 sig_out", {31'd0, sig_out}, 0);

    cur_req = "R1";  set_words(1); run_mf(0, 0, 0); check_flags("R1");
    cur_req = "R2";  set_words(2); run_mf(1, 1, 0); check_flags("R2");
    clear_flags(24'h00F00F);
    clear_flags('1);
    cur_req = "R3";  set_words(3); run_mf(1, 0, 0); check_flags("R3");
    clear_flags('1);
    extract_en = 24'hA5A5A5;
    cur_req = "R5";  set_words(4); run_mf(1, 1, 0); check_flags("R5");
    clear_flags('1);
    extract_en = '1;
    cur_req = "R7";  set_words(5); run_mf(1, 1, 3); check_flags("R7 freeze");
    set_words(6); run_mf(1, 1, 1); check_flags("R7 lof");
    set_words(7); run_mf(0, 0, 2); check_flags("R7 slip");
    deb_en = 1;
    cur_req = "R6";  set_words(8); run_mf(1, 1, 0); check_flags("R6 first");
    run_mf(1, 1, 0); check_flags("R6 second");
    sig_ie = 0;
    repeat (2) @(negedge clk);
    check_flags("R10 disabled");
    deb_en = 0;
    cur_req = "R4";  set_words(9); run_mf(1, 1, 0); check_flags("R4");
    repeat (4) @(negedge clk);
    chk("R11 queue drained", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule